// File: doc/BRIEF.md
# SPI Slave Register Bank

This block lets an external SPI master reach a small bank of byte-wide registers. A transaction is framed by an active-low chip select and carries two bytes: a command byte that names a register and says whether it is read or written, then a data byte. Control registers drive the `ctrl_o` bus for the rest of the chip. Status registers hold a snapshot of the `stat_i` bus.

All SPI inputs are brought into the system clock domain through synchronisers. SCLK edges are then detected by oversampling, so the SPI clock must be several times slower than `clk_i`. A write never changes a control register while the frame is running. The new value is committed when chip select returns high. Status snapshots are taken only while the bus is idle, so a frame always sees one frozen set of status values.

The transmit side is pipelined. The output buffer is reloaded only at the boundary of each received byte, from the register named by the most recent command. As a result, every byte returned to the master belongs to the command received before it. The first byte of a frame repeats whatever the previous frame left in the buffer.

Top module: `spi_regbank`

## Requirements
- R1: After reset every control register reads 0x00 on `ctrl_o`, and the first byte shifted out in the first frame is 0x00.
- R2: The bus runs in SPI mode 0, MSB first. MOSI is sampled on rising SCLK and MISO changes only after falling SCLK. In the command byte, bit 7 set means write and bit 7 clear means read, and bits 4:0 hold the register address.
- R3: The transmit buffer is reloaded only at the eighth falling SCLK edge of each byte, from the register addressed by the latest command. During the data byte of a write, MISO therefore carries the old contents of the addressed register.
- R4: The first byte of a frame repeats the buffer loaded at the end of the previous frame. A read issued right after a write to the same address returns the old value in its command byte and the new value in its data byte.
- R5: A write of a full 16-bit frame reaches `ctrl_o` only after chip select rises. `ctrl_o` holds its value for the whole frame.
- R6: A frame ended after fewer than 16 SCLK cycles changes no control register.
- R7: Addresses 0 to 3 are read/write control registers and addresses 4 to 7 are read-only status registers. Writes to addresses 4 to 31 are ignored. Addresses 8 to 31 read as 0x00.
- R8: Status register k (address 4+k) holds `stat_i[8k+7:8k]`. It is refreshed on every clock while chip select is high and frozen while chip select is low, so a read returns the value present before the frame began.
- R9: While chip select is high, `miso_oe_o` is 0 and `miso_o` is driven low. During a frame `miso_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from the master |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, low when not selected |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| stat_i | input | N_STAT*DATA_W | Internal status values, register k in slice k |
| ctrl_o | output | N_CTRL*DATA_W | Control register contents, register k in slice k |

## Verification
The hardest situation to reach is a mismatch between the pipelined output and a register that has just changed. Examples are a read-back straight after a write, a status input that moves in the middle of a frame, and a frame cut short after a partial byte. The bench reaches each one by driving whole frames bit by bit through a master task. That task can stop after any number of SCLK cycles and can change `stat_i` after the command byte. A reference model of the one-byte lag predicts every returned byte, including the stale byte at the start of each frame.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
   // Position of the byte currently being received within a frame.
   typedef enum logic [1:0] {
      PH_CMD   = 2'd0,
      PH_DATA  = 2'd1,
      PH_EXTRA = 2'd2
   } byte_ph_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_rb_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter
   import spi_rb_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sclk_s_i,
   input  logic              mosi_s_i,
   input  logic              cs_s_i,      // synchronised chip select, 1 = idle
   input  logic [DATA_W-1:0] rdata_i,
   output logic              sclk_fall_o,
   output logic              byte_done_o,
   output byte_ph_e          byte_ph_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic [DATA_W-1:0] tx_buf_o,
   output logic              tx_bit_o
);
   localparam int               CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

   logic              sclk_q;
   logic              sel;
   logic              rise;
   logic [CNT_W-1:0]  rx_cnt;
   logic [CNT_W-1:0]  tx_idx;
   logic [DATA_W-1:0] rx_sr;
   logic [DATA_W-1:0] rx_next;
   logic [DATA_W-1:0] tx_buf;
   byte_ph_e          byte_ph;

   assign sel         = ~cs_s_i;
   assign rise        = sel &  sclk_s_i & ~sclk_q;
   assign sclk_fall_o = sel & ~sclk_s_i &  sclk_q;
   assign rx_next     = {rx_sr[DATA_W-2:0], mosi_s_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_q  <= 1'b0;
         rx_cnt  <= '0;
         tx_idx  <= '0;
         rx_sr   <= '0;
         tx_buf  <= '0;
         byte_ph <= PH_CMD;
      end else begin
         sclk_q <= sclk_s_i;
         if (cs_s_i) begin
            rx_cnt  <= '0;
            tx_idx  <= '0;
            byte_ph <= PH_CMD;
         end else begin
            if (rise) begin
               rx_sr <= rx_next;
               if (rx_cnt == LAST) begin
                  rx_cnt <= '0;
                  if (byte_ph != PH_EXTRA) byte_ph <= byte_ph_e'(byte_ph + 2'd1);
               end else begin
                  rx_cnt <= rx_cnt + 1'b1;
               end
            end
            // Byte boundary: reload the buffer from the selected register.
            if (sclk_fall_o) begin
               if (tx_idx == LAST) begin
                  tx_idx <= '0;
                  tx_buf <= rdata_i;
               end else begin
                  tx_idx <= tx_idx + 1'b1;
               end
            end
         end
      end
   end

   assign byte_done_o = rise & (rx_cnt == LAST);
   assign byte_ph_o   = byte_ph;
   assign rx_byte_o   = rx_next;
   assign tx_buf_o    = tx_buf;
   assign tx_bit_o    = tx_buf[LAST - tx_idx];
endmodule

// File: rtl/spi_rb_regfile.sv
module spi_rb_regfile
   import spi_rb_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                ADDR_W   = 5,
   parameter int                N_CTRL   = 4,
   parameter int                N_STAT   = 4,
   parameter logic [DATA_W-1:0] CTRL_RST = '0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     cs_s_i,
   input  logic                     cs_rise_i,
   input  logic                     byte_done_i,
   input  byte_ph_e                 byte_ph_i,
   input  logic [DATA_W-1:0]        rx_byte_i,
   input  logic [N_STAT*DATA_W-1:0] stat_i,
   output logic [DATA_W-1:0]        rdata_o,
   output logic [N_CTRL*DATA_W-1:0] ctrl_o,
   output logic [N_STAT*DATA_W-1:0] stat_snap_o
);
   logic              cmd_wr;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] wr_data;
   logic              commit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cmd_wr   <= 1'b0;
         cmd_addr <= '0;
         wr_data  <= '0;
      end else if (byte_done_i) begin
         if (byte_ph_i == PH_CMD) begin
            cmd_wr   <= rx_byte_i[DATA_W-1];
            cmd_addr <= rx_byte_i[ADDR_W-1:0];
         end else if (byte_ph_i == PH_DATA) begin
            wr_data  <= rx_byte_i;
         end
      end
   end

   // Only a frame that delivered its data byte may commit.
   assign commit = cs_rise_i & cmd_wr & (byte_ph_i == PH_EXTRA);

   for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                  q <= CTRL_RST;
         else if (commit && cmd_addr == ADDR_W'(i))    q <= wr_data;
      end
      assign ctrl_o[i*DATA_W +: DATA_W] = q;
   end

   for (genvar j = 0; j < N_STAT; j++) begin : g_stat
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     q <= '0;
         else if (cs_s_i) q <= stat_i[j*DATA_W +: DATA_W];
      end
      assign stat_snap_o[j*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < N_CTRL; i++)
         if (cmd_addr == ADDR_W'(i)) rdata_o = ctrl_o[i*DATA_W +: DATA_W];
      for (int j = 0; j < N_STAT; j++)
         if (cmd_addr == ADDR_W'(N_CTRL + j)) rdata_o = stat_snap_o[j*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
   import spi_rb_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 5,
   parameter int                N_CTRL      = 4,
   parameter int                N_STAT      = 4,
   parameter int                SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] CTRL_RST    = '0
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     sclk_i,
   input  logic                     csn_i,
   input  logic                     mosi_i,
   output logic                     miso_o,
   output logic                     miso_oe_o,
   input  logic [N_STAT*DATA_W-1:0] stat_i,
   output logic [N_CTRL*DATA_W-1:0] ctrl_o
);
   localparam int N_SYNC = 3;  // csn, sclk, mosi

   if (DATA_W < 4) begin : g_bad_width
      $error("spi_regbank: DATA_W must be at least 4");
   end
   if (ADDR_W > DATA_W - 1) begin : g_bad_addr
      $error("spi_regbank: address field overlaps the write flag");
   end
   if (N_CTRL + N_STAT > (1 << ADDR_W)) begin : g_bad_map
      $error("spi_regbank: register count exceeds address space");
   end

   logic [N_SYNC-1:0] raw_in;
   logic [N_SYNC-1:0] sync_out;
   logic              cs_sync;
   logic              cs_q;
   logic              cs_rise;
   logic              sclk_fall;
   logic              byte_done;
   byte_ph_e          byte_ph;
   logic [DATA_W-1:0] rx_byte;
   logic [DATA_W-1:0] tx_buf;
   logic              tx_bit;
   logic [DATA_W-1:0] rdata;
   logic [N_STAT*DATA_W-1:0] stat_snap;

   assign raw_in = {mosi_i, sclk_i, csn_i};

   for (genvar k = 0; k < N_SYNC; k++) begin : g_sync
      spi_rb_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (k == 0)
      ) u_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (raw_in[k]),
         .q_o    (sync_out[k])
      );
   end

   assign cs_sync = sync_out[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_q <= 1'b1;
      else         cs_q <= cs_sync;
   end
   assign cs_rise = cs_sync & ~cs_q;

   spi_rb_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sclk_s_i    (sync_out[1]),
      .mosi_s_i    (sync_out[2]),
      .cs_s_i      (cs_sync),
      .rdata_i     (rdata),
      .sclk_fall_o (sclk_fall),
      .byte_done_o (byte_done),
      .byte_ph_o   (byte_ph),
      .rx_byte_o   (rx_byte),
      .tx_buf_o    (tx_buf),
      .tx_bit_o    (tx_bit)
   );

   spi_rb_regfile #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .N_CTRL   (N_CTRL),
      .N_STAT   (N_STAT),
      .CTRL_RST (CTRL_RST)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_s_i      (cs_sync),
      .cs_rise_i   (cs_rise),
      .byte_done_i (byte_done),
      .byte_ph_i   (byte_ph),
      .rx_byte_i   (rx_byte),
      .stat_i      (stat_i),
      .rdata_o     (rdata),
      .ctrl_o      (ctrl_o),
      .stat_snap_o (stat_snap)
   );

   assign miso_oe_o = ~cs_sync;
   assign miso_o    = ~cs_sync & tx_bit;
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
   parameter int DATA_W = 8,
   parameter int N_CTRL = 4,
   parameter int N_STAT = 4
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     csn_i,
   input logic                     miso_o,
   input logic                     miso_oe_o,
   input logic [N_CTRL*DATA_W-1:0] ctrl_o,
   input logic                     cs_s,
   input logic                     cs_rise,
   input logic                     sclk_fall,
   input logic [1:0]               byte_ph,
   input logic [DATA_W-1:0]        tx_buf,
   input logic [N_STAT*DATA_W-1:0] stat_snap
);
   // R2: inside a frame MISO moves only after a detected falling SCLK edge
   a_r2_miso_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$stable(miso_o) && !cs_s && $past(!cs_s)) |-> $past(sclk_fall));

   // R3: buffer reloads only on a falling SCLK edge
   a_r3_buf_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(tx_buf) |-> $past(sclk_fall));

   // R5: control outputs move only right after chip select rises
   a_r5_commit_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ctrl_o) |-> $past(cs_rise));

   // R6: a frame without a complete data byte leaves control registers alone
   a_r6_short_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cs_rise && byte_ph != 2'd2) |=> $stable(ctrl_o));

   // R8: snapshot frozen while selected
   a_r8_status_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cs_s && $past(!cs_s)) |-> $stable(stat_snap));

   // R9: idle bus leaves MISO disabled and low (holds for up to 3 sync stages)
   a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3))
         |-> (!miso_oe_o && !miso_o));
endmodule

bind spi_regbank spi_regbank_chk #(
   .DATA_W (DATA_W),
   .N_CTRL (N_CTRL),
   .N_STAT (N_STAT)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .csn_i     (csn_i),
   .miso_o    (miso_o),
   .miso_oe_o (miso_oe_o),
   .ctrl_o    (ctrl_o),
   .cs_s      (cs_sync),
   .cs_rise   (cs_rise),
   .sclk_fall (sclk_fall),
   .byte_ph   (byte_ph),
   .tx_buf    (tx_buf),
   .stat_snap (stat_snap)
);

// File: tb/spi_regbank_bench.sv
module spi_regbank_bench;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        csn = 1'b1;
   logic        mosi = 1'b0;
   logic [31:0] stat = '0;
   logic        miso;
   logic        oe;
   logic [31:0] ctrl;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spi_regbank u_spi_regbank (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .sclk_i    (sclk),
      .csn_i     (csn),
      .mosi_i    (mosi),
      .miso_o    (miso),
      .miso_oe_o (oe),
      .stat_i    (stat),
      .ctrl_o    (ctrl)
   );

   // scoreboard queues
   string       exp_r[$];
   logic [31:0] exp_v[$];
   logic [31:0] obs_v[$];

   // reference model
   logic [7:0] m_ctrl [4];
   logic [7:0] m_snap [4];
   logic [7:0] m_buf;

   function automatic logic [7:0] m_rd(input int a);
      if (a < 4)      return m_ctrl[a];
      else if (a < 8) return m_snap[a-4];
      else            return 8'h00;
   endfunction

   function automatic logic [31:0] m_flat();
      return {m_ctrl[3], m_ctrl[2], m_ctrl[1], m_ctrl[0]};
   endfunction

   task automatic push(input string r, input logic [31:0] e, input logic [31:0] o);
      exp_r.push_back(r);
      exp_v.push_back(e);
      obs_v.push_back(o);
   endtask

   // monitor
   always @(negedge clk) begin
      while (exp_v.size() > 0 && obs_v.size() > 0) begin
         string       r;
         logic [31:0] e;
         logic [31:0] o;
         r = exp_r.pop_front();
         e = exp_v.pop_front();
         o = obs_v.pop_front();
         total++;
         if (o !== e) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, o, e);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: one frame of nbits SCLK cycles; stat_mid applied after command byte.
   task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                        input logic [31:0] stat_mid, input string r0, input string r1,
                        input string rc);
      logic [15:0] tx;
      logic [15:0] rx;
      logic [7:0]  e0;
      logic [7:0]  e1;
      tx = {cmd, dat};
      rx = '0;
      e1 = '0;
      for (int k = 0; k < 4; k++) m_snap[k] = stat[k*8 +: 8];
      e0 = m_buf;
      csn = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[15-i];
         tick(HALF);
         rx[15-i] = miso;
         if (i == 0) push("R9", 32'd1, {31'd0, oe});
         sclk = 1'b1;
         tick(HALF);
         sclk = 1'b0;
         if (i == 7) begin
            m_buf = m_rd(int'(cmd[4:0]));
            e1 = m_buf;
            stat = stat_mid;
         end
         if (i == 15) m_buf = m_rd(int'(cmd[4:0]));
      end
      tick(HALF);
      push("R5", m_flat(), ctrl);      // unchanged before chip select rises
      csn = 1'b1;
      tick(3*HALF);
      if (nbits == 16 && cmd[7] && cmd[4:0] < 5'd4) m_ctrl[cmd[1:0]] = dat;
      if (nbits >= 8)  push(r0, {24'd0, e0}, {24'd0, rx[15:8]});
      if (nbits == 16) push(r1, {24'd0, e1}, {24'd0, rx[7:0]});
      push(rc, m_flat(), ctrl);
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin
         m_ctrl[k] = 8'h00;
         m_snap[k] = 8'h00;
      end
      m_buf = 8'h00;
      stat = 32'h4433_2211;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      push("R1", 32'h0, ctrl);
      push("R9", 32'h0, {30'd0, oe, miso});

      // write then read back (R1 first byte, R3 old data, R4 lag)
      frame(8'h82, 8'hA5, 16, stat, "R1", "R3", "R5");
      frame(8'h02, 8'h00, 16, stat, "R4", "R4", "R5");
      // R2: encoding and bit order over several patterns
      frame(8'h80, 8'h3C, 16, stat, "R2", "R3", "R5");
      frame(8'h81, 8'h81, 16, stat, "R2", "R3", "R5");
      frame(8'h83, 8'hFF, 16, stat, "R2", "R3", "R5");
      frame(8'h00, 8'h00, 16, stat, "R2", "R2", "R5");
      frame(8'h01, 8'h00, 16, stat, "R2", "R2", "R5");
      frame(8'h03, 8'h00, 16, stat, "R2", "R2", "R5");
      // R8: status frozen although stat_i moves mid-frame
      frame(8'h04, 8'h00, 16, 32'hDEAD_BEEF, "R4", "R8", "R8");
      frame(8'h05, 8'h00, 16, stat, "R8", "R8", "R8");
      frame(8'h06, 8'h00, 16, stat, "R8", "R8", "R8");
      frame(8'h07, 8'h00, 16, stat, "R8", "R8", "R8");
      // R7: writes to read-only and unmapped addresses
      frame(8'h85, 8'h00, 16, stat, "R7", "R7", "R7");
      frame(8'h05, 8'h00, 16, stat, "R7", "R7", "R7");
      frame(8'h94, 8'h77, 16, stat, "R7", "R7", "R7");
      frame(8'h14, 8'h00, 16, stat, "R7", "R7", "R7");
      // R6: aborted frames
      frame(8'h81, 8'h55, 12, stat, "R6", "R6", "R6");
      frame(8'h81, 8'h55, 5,  stat, "R6", "R6", "R6");
      frame(8'h01, 8'h00, 16, stat, "R6", "R6", "R6");
      // chained reads then write then read-back
      frame(8'h04, 8'h00, 16, stat, "R4", "R4", "R5");
      frame(8'h05, 8'h00, 16, stat, "R4", "R4", "R5");
      frame(8'h82, 8'h5A, 16, stat, "R4", "R3", "R5");
      frame(8'h02, 8'h00, 16, stat, "R4", "R4", "R5");
      push("R9", 32'h0, {30'd0, oe, miso});
      tick(4);
      done = 1'b1;
   end

   initial begin
      int cnt;
      cnt = 0;
      while (!done && cnt < 100000) begin
         @(negedge clk);
         cnt++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      tick(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule